// File: doc/BRIEF.md
# DMA Channel Layer Register Block

This block holds the control and status registers of a multi-channel DMA layer that sits on a control-register bus. Software reaches it through a single-cycle request port carrying a 10-bit register index, a write flag and 32 bits of write data. A read returns its data on a registered output one cycle later. The block holds a global configuration word, an error status word, an interrupt enable word, set and clear words for the transmit and receive channel-active state, and per-direction end-of-buffer and descriptor-error status words. For each channel it also holds a transmit or receive descriptor table pointer, and each receive channel has a buffer size.

The number of transmit channels and the number of receive channels are parameters, each between 1 and 32. The per-channel registers sit in three fixed windows of 32 indices. An index in a window at or above the channel count for that window is unmapped. Status bits are raised by event inputs from the DMA engine and are cleared by software writing ones. Writing the configuration word with its top bit set performs a soft reset of the control and status state. Descriptor fetch and data movement are handled elsewhere.

Top module: `dma_chan_regs`

## Requirements
- R1: After hardware reset, configuration (index 0x180) reads 0x0007C000. Error status, interrupt enable, the four active words and the four end-of-buffer and descriptor-error status words read 0. The read-data output is 0.
- R2: A write to configuration stores the written value ANDed with 0x00FFC087.
- R3: A configuration write with bit 31 set clears error status, interrupt enable, all four active words and all four per-direction status words, and stores the masked value in configuration. Table pointers and buffer sizes keep their values.
- R4: Writing to error status (0x181), transmit end-of-buffer (0x186), transmit descriptor-error (0x187), receive end-of-buffer (0x192) or receive descriptor-error (0x193) clears each bit written as 1 and keeps every other bit.
- R5: A high bit on an event input sets the matching status bit. The error event is bit-for-bit. Each channel event bit c sets status bit c. When a set and a software clear land on the same bit in the same cycle, the bit ends up set.
- R6: Interrupt enable (0x182) keeps bits 4:0. Transmit active set and clear (0x184, 0x185) keep bits 31:28. Receive active set and clear (0x190, 0x191) keep bits 31:30. All other bits read 0.
- R7: Transmit table pointer c is at 0x1A0+c and receive table pointer c is at 0x1C0+c; both store all 32 bits. Receive buffer size c is at 0x1E0+c and keeps only bits 7:0.
- R8: Reads of an unmapped index return 0, and writes to one change nothing. Unmapped indices are 0x183, any index outside the listed registers, and any window index at or above its channel count.
- R9: Read data appears on the output in the cycle after the read request. The output holds its value through cycles without a read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Register access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIndex | input | 10 | Register index |
| reqWdata | input | 32 | Write data |
| errEvent | input | 32 | Error status set pulses |
| txEobEvent | input | TX_CH | Transmit end-of-buffer set pulses, one per channel |
| txDescEvent | input | TX_CH | Transmit descriptor-error set pulses |
| rxEobEvent | input | RX_CH | Receive end-of-buffer set pulses |
| rxDescEvent | input | RX_CH | Receive descriptor-error set pulses |
| rdData | output | 32 | Registered read data |

## Verification
The bench targets the window edges by reading and writing the last implemented channel index and the first one past the channel count. A design with an off-by-one limit would either store data into the phantom slot or return that slot's data instead of 0. The soft reset is run after the pointers and sizes have been loaded, so a design that swept the per-channel storage, or left the enable, active or status words intact, shows a wrong value on read-back. The bench also clears some status bits by writing ones while an event raises the same bit in that cycle, where a design that let the clear win would lose the event. It also checks that rdData stays unchanged across idle and write cycles, which catches a read register that reloads on every request.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int IDX_W = 10;
  localparam int DATA_W = 32;
  localparam int CH_IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_CFG     = 10'h180;
  localparam logic [IDX_W-1:0] IDX_ERR     = 10'h181;
  localparam logic [IDX_W-1:0] IDX_IEN     = 10'h182;
  localparam logic [IDX_W-1:0] IDX_TXSET   = 10'h184;
  localparam logic [IDX_W-1:0] IDX_TXCLR   = 10'h185;
  localparam logic [IDX_W-1:0] IDX_TXEOB   = 10'h186;
  localparam logic [IDX_W-1:0] IDX_TXDERR  = 10'h187;
  localparam logic [IDX_W-1:0] IDX_RXSET   = 10'h190;
  localparam logic [IDX_W-1:0] IDX_RXCLR   = 10'h191;
  localparam logic [IDX_W-1:0] IDX_RXEOB   = 10'h192;
  localparam logic [IDX_W-1:0] IDX_RXDERR  = 10'h193;
  localparam logic [IDX_W-1:0] IDX_TXPTR   = 10'h1A0;
  localparam logic [IDX_W-1:0] IDX_RXPTR   = 10'h1C0;
  localparam logic [IDX_W-1:0] IDX_RXSZ    = 10'h1E0;

  localparam logic [IDX_W-CH_IDX_W-1:0] WIN_TXPTR = IDX_TXPTR[IDX_W-1:CH_IDX_W];
  localparam logic [IDX_W-CH_IDX_W-1:0] WIN_RXPTR = IDX_RXPTR[IDX_W-1:CH_IDX_W];
  localparam logic [IDX_W-CH_IDX_W-1:0] WIN_RXSZ  = IDX_RXSZ[IDX_W-1:CH_IDX_W];

  localparam logic [DATA_W-1:0] CFG_MASK   = 32'h00FF_C087;
  localparam logic [DATA_W-1:0] CFG_INIT   = 32'h0007_C000;
  localparam logic [DATA_W-1:0] IEN_MASK   = 32'h0000_001F;
  localparam logic [DATA_W-1:0] TXACT_MASK = 32'hF000_0000;
  localparam logic [DATA_W-1:0] RXACT_MASK = 32'hC000_0000;
  localparam int SIZE_W = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_ERR, SEL_IEN,
    SEL_TXSET, SEL_TXCLR, SEL_TXEOB, SEL_TXDERR,
    SEL_RXSET, SEL_RXCLR, SEL_RXEOB, SEL_RXDERR,
    SEL_TXPTR, SEL_RXPTR, SEL_RXSZ
  } regSel_e;

  typedef struct packed {
    logic                wrEn;
    logic                rdEn;
    logic                softRst;
    regSel_e             sel;
    logic [CH_IDX_W-1:0] chan;
  } regStrobe_t;

endpackage

// File: rtl/dma_chan_regs_ctrl.sv
module dma_chan_regs_ctrl
  import dma_chan_regs_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 3
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic             cfgResetBit,
  output regStrobe_t       stb
);

  logic [CH_IDX_W-1:0]       offs;
  logic [IDX_W-CH_IDX_W-1:0] win;
  regSel_e                   sel;

  assign offs = reqIndex[CH_IDX_W-1:0];
  assign win  = reqIndex[IDX_W-1:CH_IDX_W];

  always_comb begin
    sel = SEL_NONE;
    case (reqIndex)
      IDX_CFG:    sel = SEL_CFG;
      IDX_ERR:    sel = SEL_ERR;
      IDX_IEN:    sel = SEL_IEN;
      IDX_TXSET:  sel = SEL_TXSET;
      IDX_TXCLR:  sel = SEL_TXCLR;
      IDX_TXEOB:  sel = SEL_TXEOB;
      IDX_TXDERR: sel = SEL_TXDERR;
      IDX_RXSET:  sel = SEL_RXSET;
      IDX_RXCLR:  sel = SEL_RXCLR;
      IDX_RXEOB:  sel = SEL_RXEOB;
      IDX_RXDERR: sel = SEL_RXDERR;
      default:    sel = SEL_NONE;
    endcase
    // Per-channel windows: only slots below the channel count are mapped (R8)
    if (win == WIN_TXPTR && 32'(offs) < TX_CH) sel = SEL_TXPTR;
    if (win == WIN_RXPTR && 32'(offs) < RX_CH) sel = SEL_RXPTR;
    if (win == WIN_RXSZ  && 32'(offs) < RX_CH) sel = SEL_RXSZ;
  end

  always_comb begin
    stb.wrEn    = reqValid && reqWrite;
    stb.rdEn    = reqValid && !reqWrite;
    stb.softRst = reqValid && reqWrite && (sel == SEL_CFG) && cfgResetBit;
    stb.sel     = sel;
    stb.chan    = offs;
  end

endmodule

// File: rtl/dma_chan_regs_dp.sv
module dma_chan_regs_dp
  import dma_chan_regs_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] errEvent,
  input  logic [TX_CH-1:0]  txEobEvent,
  input  logic [TX_CH-1:0]  txDescEvent,
  input  logic [RX_CH-1:0]  rxEobEvent,
  input  logic [RX_CH-1:0]  rxDescEvent,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cfgReg, errReg, ienReg;
  logic [DATA_W-1:0] txSetReg, txClrReg, txEobReg, txDerrReg;
  logic [DATA_W-1:0] rxSetReg, rxClrReg, rxEobReg, rxDerrReg;
  logic [DATA_W-1:0] txPtr [TX_CH];
  logic [DATA_W-1:0] rxPtr [RX_CH];
  logic [SIZE_W-1:0] rxSize [RX_CH];
  logic [DATA_W-1:0] rdNext;
  regSel_e           wrSel;

  assign wrSel = stb.wrEn ? stb.sel : SEL_NONE;

  // Set from events wins over a same-cycle software clear (R5)
  function automatic logic [DATA_W-1:0] w1cNext(
    input logic [DATA_W-1:0] cur,
    input logic              hit,
    input logic [DATA_W-1:0] wd,
    input logic [DATA_W-1:0] setv
  );
    return (cur & ~(hit ? wd : '0)) | setv;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= CFG_INIT;
      errReg    <= '0;
      ienReg    <= '0;
      txSetReg  <= '0;
      txClrReg  <= '0;
      txEobReg  <= '0;
      txDerrReg <= '0;
      rxSetReg  <= '0;
      rxClrReg  <= '0;
      rxEobReg  <= '0;
      rxDerrReg <= '0;
    end else if (stb.softRst) begin
      cfgReg    <= wdata & CFG_MASK;
      errReg    <= '0;
      ienReg    <= '0;
      txSetReg  <= '0;
      txClrReg  <= '0;
      txEobReg  <= '0;
      txDerrReg <= '0;
      rxSetReg  <= '0;
      rxClrReg  <= '0;
      rxEobReg  <= '0;
      rxDerrReg <= '0;
    end else begin
      if (wrSel == SEL_CFG)   cfgReg   <= wdata & CFG_MASK;
      if (wrSel == SEL_IEN)   ienReg   <= wdata & IEN_MASK;
      if (wrSel == SEL_TXSET) txSetReg <= wdata & TXACT_MASK;
      if (wrSel == SEL_TXCLR) txClrReg <= wdata & TXACT_MASK;
      if (wrSel == SEL_RXSET) rxSetReg <= wdata & RXACT_MASK;
      if (wrSel == SEL_RXCLR) rxClrReg <= wdata & RXACT_MASK;
      errReg    <= w1cNext(errReg,    wrSel == SEL_ERR,    wdata, errEvent);
      txEobReg  <= w1cNext(txEobReg,  wrSel == SEL_TXEOB,  wdata, DATA_W'(txEobEvent));
      txDerrReg <= w1cNext(txDerrReg, wrSel == SEL_TXDERR, wdata, DATA_W'(txDescEvent));
      rxEobReg  <= w1cNext(rxEobReg,  wrSel == SEL_RXEOB,  wdata, DATA_W'(rxEobEvent));
      rxDerrReg <= w1cNext(rxDerrReg, wrSel == SEL_RXDERR, wdata, DATA_W'(rxDescEvent));
    end
  end

  // Per-channel storage: hardware reset only, soft reset leaves it alone
  for (genvar c = 0; c < TX_CH; c++) begin : g_tx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) txPtr[c] <= '0;
      else if (wrSel == SEL_TXPTR && stb.chan == CH_IDX_W'(c)) txPtr[c] <= wdata;
    end
  end

  for (genvar c = 0; c < RX_CH; c++) begin : g_rx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxPtr[c]  <= '0;
        rxSize[c] <= '0;
      end else begin
        if (wrSel == SEL_RXPTR && stb.chan == CH_IDX_W'(c)) rxPtr[c] <= wdata;
        if (wrSel == SEL_RXSZ && stb.chan == CH_IDX_W'(c)) rxSize[c] <= wdata[SIZE_W-1:0];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (stb.sel)
      SEL_CFG:    rdNext = cfgReg;
      SEL_ERR:    rdNext = errReg;
      SEL_IEN:    rdNext = ienReg;
      SEL_TXSET:  rdNext = txSetReg;
      SEL_TXCLR:  rdNext = txClrReg;
      SEL_TXEOB:  rdNext = txEobReg;
      SEL_TXDERR: rdNext = txDerrReg;
      SEL_RXSET:  rdNext = rxSetReg;
      SEL_RXCLR:  rdNext = rxClrReg;
      SEL_RXEOB:  rdNext = rxEobReg;
      SEL_RXDERR: rdNext = rxDerrReg;
      SEL_TXPTR:
        for (int c = 0; c < TX_CH; c++)
          if (stb.chan == CH_IDX_W'(c)) rdNext = txPtr[c];
      SEL_RXPTR:
        for (int c = 0; c < RX_CH; c++)
          if (stb.chan == CH_IDX_W'(c)) rdNext = rxPtr[c];
      SEL_RXSZ:
        for (int c = 0; c < RX_CH; c++)
          if (stb.chan == CH_IDX_W'(c)) rdNext = DATA_W'(rxSize[c]);
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] errEvent,
  input  logic [TX_CH-1:0]  txEobEvent,
  input  logic [TX_CH-1:0]  txDescEvent,
  input  logic [RX_CH-1:0]  rxEobEvent,
  input  logic [RX_CH-1:0]  rxDescEvent,
  output logic [DATA_W-1:0] rdData
);

  regStrobe_t stb;

  dma_chan_regs_ctrl #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_ctrl (
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqIndex    (reqIndex),
    .cfgResetBit (reqWdata[DATA_W-1]),
    .stb         (stb)
  );

  dma_chan_regs_dp #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (reqWdata),
    .errEvent    (errEvent),
    .txEobEvent  (txEobEvent),
    .txDescEvent (txDescEvent),
    .rxEobEvent  (rxEobEvent),
    .rxDescEvent (rxDescEvent),
    .rdData      (rdData)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_regs_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [IDX_W-1:0]  reqIndex,
  input logic [DATA_W-1:0] rdData
);

  logic isRead;
  assign isRead = reqValid && !reqWrite;

  a_r9_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(rdData));

  a_r8_gap_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex == 10'h183 |=> rdData == '0);

  a_r8_tx_window_limit: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex[IDX_W-1:CH_IDX_W] == WIN_TXPTR
      && 32'(reqIndex[CH_IDX_W-1:0]) >= TX_CH |=> rdData == '0);

  a_r8_rx_window_limit: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex[IDX_W-1:CH_IDX_W] == WIN_RXPTR
      && 32'(reqIndex[CH_IDX_W-1:0]) >= RX_CH |=> rdData == '0);

  a_r2_cfg_bits: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex == IDX_CFG |=> (rdData & ~CFG_MASK) == '0);

  a_r6_enable_bits: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex == IDX_IEN |=> (rdData & ~IEN_MASK) == '0);

  a_r7_size_bits: assert property (@(posedge clk) disable iff (!rstN)
    isRead && reqIndex[IDX_W-1:CH_IDX_W] == WIN_RXSZ |=> rdData[DATA_W-1:SIZE_W] == '0);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqIndex (reqIndex),
  .rdData   (rdData)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;

  localparam int TX_CH = 4;
  localparam int RX_CH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [9:0]  reqIndex = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] errEvent = '0;
  logic [TX_CH-1:0] txEobEvent = '0;
  logic [TX_CH-1:0] txDescEvent = '0;
  logic [RX_CH-1:0] rxEobEvent = '0;
  logic [RX_CH-1:0] rxDescEvent = '0;
  logic [31:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_regs #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_dma_chan_regs (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIndex(reqIndex), .reqWdata(reqWdata), .errEvent(errEvent),
    .txEobEvent(txEobEvent), .txDescEvent(txDescEvent),
    .rxEobEvent(rxEobEvent), .rxDescEvent(rxDescEvent), .rdData(rdData)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  idx;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 10'h182, 32'hFFFF_FFFF, 4'd6},
    '{1'b0, 10'h182, 32'h0000_001F, 4'd6},   // R6 enable bits 4:0
    '{1'b1, 10'h184, 32'hFFFF_FFFF, 4'd6},
    '{1'b0, 10'h184, 32'hF000_0000, 4'd6},   // R6 tx set 31:28
    '{1'b1, 10'h185, 32'h0FFF_FFFF, 4'd6},
    '{1'b0, 10'h185, 32'h0000_0000, 4'd6},   // R6 tx clear drops low bits
    '{1'b1, 10'h190, 32'hFFFF_FFFF, 4'd6},
    '{1'b0, 10'h190, 32'hC000_0000, 4'd6},   // R6 rx set 31:30
    '{1'b1, 10'h1A0, 32'hDEAD_BEEF, 4'd7},
    '{1'b0, 10'h1A0, 32'hDEAD_BEEF, 4'd7},   // R7 tx pointer 0
    '{1'b1, 10'h1A3, 32'h1234_5678, 4'd7},
    '{1'b0, 10'h1A3, 32'h1234_5678, 4'd7},   // R7 last tx channel
    '{1'b1, 10'h1A4, 32'hAAAA_AAAA, 4'd8},
    '{1'b0, 10'h1A4, 32'h0000_0000, 4'd8},   // R8 first slot past tx count
    '{1'b1, 10'h1C2, 32'hCAFE_F00D, 4'd7},
    '{1'b0, 10'h1C2, 32'hCAFE_F00D, 4'd7},   // R7 last rx pointer
    '{1'b0, 10'h1C3, 32'h0000_0000, 4'd8},   // R8 rx pointer past count
    '{1'b1, 10'h1E2, 32'hFFFF_FFFF, 4'd7},
    '{1'b0, 10'h1E2, 32'h0000_00FF, 4'd7},   // R7 size low 8 bits
    '{1'b1, 10'h1E3, 32'h0000_0055, 4'd8},
    '{1'b0, 10'h1E3, 32'h0000_0000, 4'd8},   // R8 size past count
    '{1'b1, 10'h180, 32'h7FFF_FFFF, 4'd2},
    '{1'b0, 10'h180, 32'h00FF_C087, 4'd2},   // R2 config mask
    '{1'b0, 10'h183, 32'h0000_0000, 4'd8}    // R8 gap index
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqIndex = idx; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] idx, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqIndex = idx;
    @(negedge clk);
    reqValid = 1'b0;
    d = rdData;
  endtask

  task automatic readCheck(input string tag, input logic [9:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    doRead(idx, d);
    check(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 rdData after reset", rdData, 32'h0);
    rstN = 1'b1;

    // R1 reset values
    readCheck("R1 config reset", 10'h180, 32'h0007_C000);
    foreach (VECS[i]) begin end
    readCheck("R1 error reset", 10'h181, 0);
    readCheck("R1 enable reset", 10'h182, 0);
    readCheck("R1 tx set reset", 10'h184, 0);
    readCheck("R1 tx clear reset", 10'h185, 0);
    readCheck("R1 tx eob reset", 10'h186, 0);
    readCheck("R1 tx derr reset", 10'h187, 0);
    readCheck("R1 rx set reset", 10'h190, 0);
    readCheck("R1 rx clear reset", 10'h191, 0);
    readCheck("R1 rx eob reset", 10'h192, 0);
    readCheck("R1 rx derr reset", 10'h193, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) doWrite(VECS[i].idx, VECS[i].data);
      else begin
        doRead(VECS[i].idx, d);
        check($sformatf("R%0d vector %0d index %03h", VECS[i].req, i, VECS[i].idx),
              d, VECS[i].data);
      end
    end

    // R5 events set status bits, channel c -> bit c
    @(negedge clk);
    txEobEvent = 4'b1010; errEvent = 32'h0000_0F0F; txDescEvent = 4'b0001;
    rxDescEvent = 3'b100;
    @(negedge clk);
    txEobEvent = '0; errEvent = '0; txDescEvent = '0; rxDescEvent = '0;
    readCheck("R5 tx eob set", 10'h186, 32'h0000_000A);
    readCheck("R5 error set", 10'h181, 32'h0000_0F0F);
    readCheck("R5 tx derr set", 10'h187, 32'h0000_0001);
    readCheck("R5 rx derr set", 10'h193, 32'h0000_0004);

    // R4 write-one-to-clear
    doWrite(10'h186, 32'h0000_0002);
    readCheck("R4 tx eob partial clear", 10'h186, 32'h0000_0008);
    doWrite(10'h181, 32'h0000_0003);
    readCheck("R4 error partial clear", 10'h181, 32'h0000_0F0C);
    doWrite(10'h193, 32'hFFFF_FFFF);
    readCheck("R4 rx derr full clear", 10'h193, 32'h0);

    // R5 set wins over same-cycle clear
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqIndex = 10'h192; reqWdata = 32'h1;
    rxEobEvent = 3'b001;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; rxEobEvent = '0;
    readCheck("R5 set beats clear", 10'h192, 32'h0000_0001);

    // R9 hold across idle and write cycles
    doRead(10'h1A0, d);
    check("R9 read latency", d, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    check("R9 hold idle", rdData, 32'hDEAD_BEEF);
    doWrite(10'h182, 32'h0000_0005);
    check("R9 hold over write", rdData, 32'hDEAD_BEEF);

    // R8 write to unmapped window slot must not alias channel 0
    readCheck("R8 tx ptr 0 untouched", 10'h1A0, 32'hDEAD_BEEF);

    // R3 soft reset
    doWrite(10'h184, 32'hF000_0000);
    doWrite(10'h180, 32'h8000_0001);
    readCheck("R3 config after soft reset", 10'h180, 32'h0000_0001);
    readCheck("R3 enable cleared", 10'h182, 0);
    readCheck("R3 tx set cleared", 10'h184, 0);
    readCheck("R3 rx set cleared", 10'h190, 0);
    readCheck("R3 tx eob cleared", 10'h186, 0);
    readCheck("R3 error cleared", 10'h181, 0);
    readCheck("R3 rx eob cleared", 10'h192, 0);
    readCheck("R3 tx ptr kept", 10'h1A0, 32'hDEAD_BEEF);
    readCheck("R3 rx ptr kept", 10'h1C2, 32'hCAFE_F00D);
    readCheck("R3 size kept", 10'h1E2, 32'h0000_00FF);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule